// File: doc/BRIEF.md
# Serial-Configured Pad Control Cell

This block is a single configuration cell that sits next to one I/O pad. Cells are chained: each cell's serial input comes from the previous cell's serial output, and the first cell takes its input from the loader's data line. A shared serial clock shifts bits through every cell while the shift enable is high. A shared load strobe then copies each cell's shift register into a shadow register in the same cycle for all cells. The shadow register alone drives the pad's electrical controls. Because of this, a pad does not change while a new stream is moving through the chain.

The configuration word also chooses who owns the pad. Under management control the pad output comes from the management side. In the full-bidirectional flavour the pad enable also comes from the management side. In the selectable flavour it comes from the stored configuration. Under user control the user's output data and enable reach the pad. Pad input is always copied to both sides. The loader reset is active-low and asynchronous. It clears the shift register and restores the shadow register to a default set by parameter. So the reset always takes a pad back from user logic.

Top module: `pad_cfg_cell`

## Requirements
- R1: While rstN is low, the shift register clears and the shadow register takes RESET_CFG. The default for FULL_BIDIR=1 is management control, output enabled and drive mode 3'b110. The default for FULL_BIDIR=0 is management control, padOeb=1, input disabled off and drive mode 3'b001.
- R2: serOut is the most significant bit of the shift register. A bit presented at serIn with shiftEn high appears at serOut after exactly 13 clock edges, and bits move left by one position per edge. In a chain, the first bit sent therefore ends in the cell farthest from the loader.
- R3: No pad control output changes on an edge where loadStb is low.
- R4: On an edge with loadStb high, the shadow register takes the shift register contents. The 13-bit word, sent most significant bit first, decodes as follows: bit0 = management control, bit1 = stored output-disable, bit2 = holdover, bit3 = input disable, bit4 = input buffer mode, bit5 = analog enable, bit6 = analog select, bit7 = analog polarity, bit8 = slow slew, bit9 = trip-point select, bits 12:10 = drive mode.
- R5: When loadStb and shiftEn are both high on an edge, the load takes place and the shift register does not move.
- R6: In the full-bidirectional flavour under management control, padOut equals mgmtOut and padOeb equals mgmtOeb.
- R7: In the selectable flavour under management control, padOut equals mgmtOut and padOeb equals the stored output-disable bit. mgmtOeb has no effect.
- R8: Under user control (bit0 = 0), padOut equals userOut and padOeb equals userOeb. mgmtOut and mgmtOeb have no effect.
- R9: userIn and mgmtIn always equal padIn.
- R10: tieOne is constant 1.
- R11: A reset pulse after user control was loaded returns the pad to its default management function.
- R12: With shiftEn and loadStb low, clock edges leave the shift register unchanged. A later load therefore reproduces the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial configuration clock |
| rstN | input | 1 | Asynchronous active-low loader reset |
| shiftEn | input | 1 | Shift the chain by one bit on this edge |
| loadStb | input | 1 | Copy the shift register into the shadow register |
| serIn | input | 1 | Serial data from the previous cell or the loader |
| serOut | output | 1 | Serial data to the next cell |
| mgmtOut | input | 1 | Management output data |
| mgmtOeb | input | 1 | Management output disable (active high) |
| mgmtIn | output | 1 | Pad input seen by management |
| userOut | input | 1 | User output data |
| userOeb | input | 1 | User output disable (active high) |
| userIn | output | 1 | Pad input seen by user logic |
| padIn | input | 1 | Data received from the pad |
| padOut | output | 1 | Data driven to the pad |
| padOeb | output | 1 | Pad output disable (active high) |
| padInDis | output | 1 | Pad input buffer disable |
| padIbMode | output | 1 | Input buffer mode select |
| padVtrip | output | 1 | Input trip-point select |
| padSlow | output | 1 | Slow slew select |
| padHold | output | 1 | Holdover select |
| padAnaEn | output | 1 | Analog enable |
| padAnaSel | output | 1 | Analog select |
| padAnaPol | output | 1 | Analog polarity |
| padDm | output | 3 | Drive mode |
| tieOne | output | 1 | Constant logic one for tying enables |

## Verification
The bench chains a full-bidirectional cell in front of a selectable cell and sends 26 bits. Each cell must end up with its own word; a design that reversed the shift direction or tapped the wrong bit would swap or scramble the two words. The bench shifts without loading and checks that the pad controls stay still; a design with a transparent shadow register would show the partial stream. It asserts load and shift together; a design that also shifted would load correctly, but a second load would show shifted fields. It also checks that mgmtOeb is ignored in the selectable flavour and that a reset after a user takeover restores management ownership. A design that let the management enable through, or did not reload defaults, would leave the wrong driver on the pad.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
  localparam int CFG_W = 13;
  localparam int DM_W  = 3;

  localparam int B_MGMT   = 0;
  localparam int B_OEB    = 1;
  localparam int B_HOLD   = 2;
  localparam int B_INDIS  = 3;
  localparam int B_IBMODE = 4;
  localparam int B_ANAEN  = 5;
  localparam int B_ANASEL = 6;
  localparam int B_ANAPOL = 7;
  localparam int B_SLOW   = 8;
  localparam int B_VTRIP  = 9;
  localparam int B_DM     = 10;

  // management owned, output enabled, drive mode 110
  localparam logic [CFG_W-1:0] CFG_FULL_DEF = 13'h1801;
  // management owned, output disabled, drive mode 001
  localparam logic [CFG_W-1:0] CFG_IN_DEF   = 13'h0403;

  typedef struct packed {
    logic shift;
    logic load;
  } cfgStb_t;

  typedef struct packed {
    logic            mgmtEn;
    logic            oeb;
    logic            hold;
    logic            inDis;
    logic            ibMode;
    logic            anaEn;
    logic            anaSel;
    logic            anaPol;
    logic            slow;
    logic            vtrip;
    logic [DM_W-1:0] dm;
  } cfgFields_t;
endpackage

// File: rtl/pad_cfg_ctrl.sv
module pad_cfg_ctrl
  import pad_cfg_pkg::*;
(
  input  logic    shiftEn,
  input  logic    loadStb,
  output cfgStb_t stb
);
  // a load wins over a shift on the same edge
  always_comb begin
    stb.load  = loadStb;
    stb.shift = shiftEn & ~loadStb;
  end
endmodule

// File: rtl/pad_cfg_dp.sv
module pad_cfg_dp
  import pad_cfg_pkg::*;
#(
  parameter bit               FULL_BIDIR = 1'b0,
  parameter logic [CFG_W-1:0] RESET_CFG  = CFG_IN_DEF
)(
  input  logic      clk,
  input  logic      rstN,
  input  cfgStb_t   stb,
  input  logic      serIn,
  output logic      serOut,
  input  logic      mgmtOut,
  input  logic      mgmtOeb,
  input  logic      userOut,
  input  logic      userOeb,
  output logic      padOut,
  output logic      padOeb,
  output cfgFields_t fields
);
  logic [CFG_W-1:0] shiftReg;
  logic [CFG_W-1:0] shadow;
  logic             mgmtSideOeb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.shift) begin
      shiftReg <= {shiftReg[CFG_W-2:0], serIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= RESET_CFG;
    end else if (stb.load) begin
      shadow <= shiftReg;
    end
  end

  assign serOut = shiftReg[CFG_W-1];

  always_comb begin
    fields.mgmtEn = shadow[B_MGMT];
    fields.oeb    = shadow[B_OEB];
    fields.hold   = shadow[B_HOLD];
    fields.inDis  = shadow[B_INDIS];
    fields.ibMode = shadow[B_IBMODE];
    fields.anaEn  = shadow[B_ANAEN];
    fields.anaSel = shadow[B_ANASEL];
    fields.anaPol = shadow[B_ANAPOL];
    fields.slow   = shadow[B_SLOW];
    fields.vtrip  = shadow[B_VTRIP];
    fields.dm     = shadow[B_DM +: DM_W];
  end

  generate
    if (FULL_BIDIR) begin : gFull
      assign mgmtSideOeb = mgmtOeb;
    end else begin : gSel
      assign mgmtSideOeb = shadow[B_OEB];
    end
  endgenerate

  always_comb begin
    if (fields.mgmtEn) begin
      padOut = mgmtOut;
      padOeb = mgmtSideOeb;
    end else begin
      padOut = userOut;
      padOeb = userOeb;
    end
  end
endmodule

// File: rtl/pad_cfg_cell.sv
module pad_cfg_cell
  import pad_cfg_pkg::*;
#(
  parameter bit               FULL_BIDIR = 1'b0,
  parameter logic [CFG_W-1:0] RESET_CFG  = FULL_BIDIR ? CFG_FULL_DEF : CFG_IN_DEF
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            shiftEn,
  input  logic            loadStb,
  input  logic            serIn,
  output logic            serOut,
  input  logic            mgmtOut,
  input  logic            mgmtOeb,
  output logic            mgmtIn,
  input  logic            userOut,
  input  logic            userOeb,
  output logic            userIn,
  input  logic            padIn,
  output logic            padOut,
  output logic            padOeb,
  output logic            padInDis,
  output logic            padIbMode,
  output logic            padVtrip,
  output logic            padSlow,
  output logic            padHold,
  output logic            padAnaEn,
  output logic            padAnaSel,
  output logic            padAnaPol,
  output logic [DM_W-1:0] padDm,
  output logic            tieOne
);
  cfgStb_t    stb;
  cfgFields_t fields;

  pad_cfg_ctrl uCtrl (
    .shiftEn (shiftEn),
    .loadStb (loadStb),
    .stb     (stb)
  );

  pad_cfg_dp #(
    .FULL_BIDIR (FULL_BIDIR),
    .RESET_CFG  (RESET_CFG)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .serIn   (serIn),
    .serOut  (serOut),
    .mgmtOut (mgmtOut),
    .mgmtOeb (mgmtOeb),
    .userOut (userOut),
    .userOeb (userOeb),
    .padOut  (padOut),
    .padOeb  (padOeb),
    .fields  (fields)
  );

  assign padInDis  = fields.inDis;
  assign padIbMode = fields.ibMode;
  assign padVtrip  = fields.vtrip;
  assign padSlow   = fields.slow;
  assign padHold   = fields.hold;
  assign padAnaEn  = fields.anaEn;
  assign padAnaSel = fields.anaSel;
  assign padAnaPol = fields.anaPol;
  assign padDm     = fields.dm;
  assign userIn    = padIn;
  assign mgmtIn    = padIn;
  assign tieOne    = 1'b1;
endmodule

// File: rtl/pad_cfg_chk.sv
module pad_cfg_chk
  import pad_cfg_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            shiftEn,
  input logic            loadStb,
  input logic            serOut,
  input logic            padIn,
  input logic            userIn,
  input logic            mgmtIn,
  input logic            padInDis,
  input logic            padIbMode,
  input logic            padVtrip,
  input logic            padSlow,
  input logic            padHold,
  input logic            padAnaEn,
  input logic            padAnaSel,
  input logic            padAnaPol,
  input logic [DM_W-1:0] padDm,
  input logic            tieOne
);
  logic [DM_W+7:0] ctlVec;
  assign ctlVec = {padDm, padInDis, padIbMode, padVtrip, padSlow,
                   padHold, padAnaEn, padAnaSel, padAnaPol};

  assert_ctl_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> $stable(ctlVec));

  assert_shift_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftEn && !loadStb) |=> $stable(serOut));

  assert_load_blocks_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> $stable(serOut));

  assert_in_copy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (userIn == padIn) && (mgmtIn == padIn));

  assert_tie_one_R10: assert property (@(posedge clk) disable iff (!rstN)
    tieOne == 1'b1);
endmodule

bind pad_cfg_cell pad_cfg_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .shiftEn   (shiftEn),
  .loadStb   (loadStb),
  .serOut    (serOut),
  .padIn     (padIn),
  .userIn    (userIn),
  .mgmtIn    (mgmtIn),
  .padInDis  (padInDis),
  .padIbMode (padIbMode),
  .padVtrip  (padVtrip),
  .padSlow   (padSlow),
  .padHold   (padHold),
  .padAnaEn  (padAnaEn),
  .padAnaSel (padAnaSel),
  .padAnaPol (padAnaPol),
  .padDm     (padDm),
  .tieOne    (tieOne)
);

// File: tb/pad_cfg_cell_test.sv
module pad_cfg_cell_test;
  localparam int PERIOD = 10;
  localparam int W = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftEn = 1'b0, loadStb = 1'b0, serIn = 1'b0;
  logic mgmtOut = 1'b0, mgmtOeb = 1'b0, userOut = 1'b0, userOeb = 1'b0, padIn = 1'b0;

  logic serA, serB, mInA, mInB, uInA, uInB, pOutA, pOutB, pOebA, pOebB;
  logic inDisA, inDisB, ibA, ibB, vtA, vtB, slA, slB, hoA, hoB;
  logic aeA, aeB, asA, asB, apA, apB, oneA, oneB;
  logic [2:0] dmA, dmB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  // uut: full bidirectional, first in chain; uutSel: selectable, fed by uut
  pad_cfg_cell #(.FULL_BIDIR(1'b1)) uut (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .loadStb(loadStb),
    .serIn(serIn), .serOut(serA),
    .mgmtOut(mgmtOut), .mgmtOeb(mgmtOeb), .mgmtIn(mInA),
    .userOut(userOut), .userOeb(userOeb), .userIn(uInA),
    .padIn(padIn), .padOut(pOutA), .padOeb(pOebA),
    .padInDis(inDisA), .padIbMode(ibA), .padVtrip(vtA), .padSlow(slA),
    .padHold(hoA), .padAnaEn(aeA), .padAnaSel(asA), .padAnaPol(apA),
    .padDm(dmA), .tieOne(oneA));

  pad_cfg_cell #(.FULL_BIDIR(1'b0)) uutSel (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .loadStb(loadStb),
    .serIn(serA), .serOut(serB),
    .mgmtOut(mgmtOut), .mgmtOeb(mgmtOeb), .mgmtIn(mInB),
    .userOut(userOut), .userOeb(userOeb), .userIn(uInB),
    .padIn(padIn), .padOut(pOutB), .padOeb(pOebB),
    .padInDis(inDisB), .padIbMode(ibB), .padVtrip(vtB), .padSlow(slB),
    .padHold(hoB), .padAnaEn(aeB), .padAnaSel(asB), .padAnaPol(apB),
    .padDm(dmB), .tieOne(oneB));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // word layout from R4
  function automatic logic [W-1:0] mkCfg(input bit mg, oeb, hold, inDis, ib,
      anaEn, anaSel, anaPol, slow, vtrip, input logic [2:0] dm);
    return {dm, vtrip, slow, anaPol, anaSel, anaEn, ib, inDis, hold, oeb, mg};
  endfunction

  function automatic logic [10:0] ctlA();
    return {dmA, vtA, slA, apA, asA, aeA, ibA, inDisA, hoA};
  endfunction
  function automatic logic [10:0] ctlB();
    return {dmB, vtB, slB, apB, asB, aeB, ibB, inDisB, hoB};
  endfunction
  function automatic logic [10:0] ctlOf(input logic [W-1:0] w);
    return w[12:2];
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; shiftEn = 1'b0; loadStb = 1'b0;
    tick();
    rstN = 1'b1;
  endtask

  task automatic shiftBit(input logic b);
    serIn = b; shiftEn = 1'b1;
    tick();
    shiftEn = 1'b0;
  endtask

  task automatic loadNow();
    loadStb = 1'b1;
    tick();
    loadStb = 1'b0;
  endtask

  task automatic tResetDefaults();
    doReset();
    chk(dmA == 3'b110, "R1 full drive mode", dmA, 3'b110);
    chk(dmB == 3'b001, "R1 sel drive mode", dmB, 3'b001);
    chk(pOebB == 1'b1, "R1 sel output disabled", pOebB, 1);
    chk(inDisA == 1'b0 && inDisB == 1'b0, "R1 input enabled", {inDisA, inDisB}, 0);
    chk(serA == 1'b0 && serB == 1'b0, "R1 shift cleared", {serA, serB}, 0);
    chk(oneA && oneB, "R10 tie one", {oneA, oneB}, 3);
    mgmtOut = 1'b1; mgmtOeb = 1'b0; #1;
    chk(pOutA == 1'b1 && pOebA == 1'b0, "R6 full follows mgmt", {pOutA, pOebA}, 2'b10);
    mgmtOut = 1'b0; mgmtOeb = 1'b1; #1;
    chk(pOutA == 1'b0 && pOebA == 1'b1, "R6 full follows mgmt oeb", {pOutA, pOebA}, 2'b01);
  endtask

  task automatic tShiftDelay();
    doReset();
    shiftBit(1'b1);
    for (int i = 1; i < W - 1; i++) shiftBit(1'b0);
    chk(serA == 1'b0, "R2 not out after 12", serA, 0);
    shiftBit(1'b0);
    chk(serA == 1'b1, "R2 out after 13", serA, 1);
    chk(ctlA() == ctlOf(13'h1801) && ctlB() == ctlOf(13'h0403),
        "R3 no change while shifting", ctlA(), ctlOf(13'h1801));
  endtask

  task automatic tChainLoad(input logic [W-1:0] wSel, input logic [W-1:0] wFull);
    doReset();
    for (int i = W - 1; i >= 0; i--) shiftBit(wSel[i]);
    for (int i = W - 1; i >= 0; i--) shiftBit(wFull[i]);
    chk(ctlA() == ctlOf(13'h1801), "R3 full unchanged before load", ctlA(), ctlOf(13'h1801));
    loadNow();
    chk(ctlA() == ctlOf(wFull), "R4 full fields", ctlA(), ctlOf(wFull));
    chk(ctlB() == ctlOf(wSel), "R4 sel fields (chain order R2)", ctlB(), ctlOf(wSel));
  endtask

  task automatic tOwnership();
    // uut in user mode (bit0=0), uutSel in mgmt mode with stored oeb 0
    userOut = 1'b1; userOeb = 1'b0; mgmtOut = 1'b0; mgmtOeb = 1'b1; #1;
    chk(pOutA == 1'b1 && pOebA == 1'b0, "R8 user drives pad", {pOutA, pOebA}, 2'b10);
    chk(pOutB == 1'b0 && pOebB == 1'b0, "R7 stored oeb, mgmtOeb ignored", {pOutB, pOebB}, 0);
    userOut = 1'b0; userOeb = 1'b1; mgmtOut = 1'b1; mgmtOeb = 1'b0; #1;
    chk(pOutA == 1'b0 && pOebA == 1'b1, "R8 mgmt ignored in user mode", {pOutA, pOebA}, 2'b01);
    chk(pOutB == 1'b1 && pOebB == 1'b0, "R7 mgmt data to pad", {pOutB, pOebB}, 2'b10);
    padIn = 1'b1; #1;
    chk(uInA && mInA && uInB && mInB, "R9 input copied high", {uInA, mInA, uInB, mInB}, 4'hF);
    padIn = 1'b0; #1;
    chk(!(uInA | mInA | uInB | mInB), "R9 input copied low", {uInA, mInA, uInB, mInB}, 0);
  endtask

  task automatic tLoadShiftTogether(input logic [W-1:0] wSel, input logic [W-1:0] wFull);
    serIn = 1'b1; shiftEn = 1'b1; loadStb = 1'b1;
    tick();
    shiftEn = 1'b0; loadStb = 1'b0;
    serIn = 1'b0;
    tick();
    loadNow();
    chk(ctlA() == ctlOf(wFull), "R5 no shift with load", ctlA(), ctlOf(wFull));
    chk(ctlB() == ctlOf(wSel), "R5 no shift with load sel", ctlB(), ctlOf(wSel));
    for (int i = 0; i < 5; i++) begin
      serIn = i[0];
      tick();
    end
    loadNow();
    chk(ctlA() == ctlOf(wFull), "R12 idle clocks keep shift reg", ctlA(), ctlOf(wFull));
  endtask

  task automatic tResetTakeback();
    doReset();
    chk(dmA == 3'b110, "R11 default drive restored", dmA, 3'b110);
    mgmtOut = 1'b1; userOut = 1'b0; mgmtOeb = 1'b0; userOeb = 1'b1; #1;
    chk(pOutA == 1'b1 && pOebA == 1'b0, "R11 mgmt owns pad again", {pOutA, pOebA}, 2'b10);
  endtask

  initial begin
    logic [W-1:0] wSel, wFull;
    wSel  = mkCfg(1, 0, 1, 1, 1, 0, 1, 1, 0, 1, 3'b101);
    wFull = mkCfg(0, 1, 0, 0, 0, 1, 0, 0, 1, 0, 3'b011);
    tResetDefaults();
    tShiftDelay();
    tChainLoad(wSel, wFull);
    tOwnership();
    tLoadShiftTogether(wSel, wFull);
    tResetTakeback();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule